// File: doc/BRIEF.md
# Double-Buffered Sprite Line Buffer

This block stores one scanline of composed sprite pixels in two halves. The render side writes sprite fragments into one half. At the same time, the display side reads the other half out, one entry per request. A pulse on `line_start` swaps the roles of the two halves. Each entry is 24 bits wide, and each half holds 512 horizontal positions. A value of zero means transparent.

A render write carries a 10-bit start position, up to eight pixels and a per-pixel valid mask. All of these land in a single cycle, at any alignment of the start position. The block counts the pixels it actually stores during the current line and compares that count against a per-line budget. The budget is 3072 or 4096, chosen by a mode input. A write that would overrun the budget is dropped as a whole, so the fragment drawn last disappears from the line. Every later write in that line is also dropped. When the display side reads an entry, the entry is wiped to zero, so a half is clean by the time it is drawn into again.

Top module: `sprite_line_buf`

## Requirements
- R1: After reset, `render_half` is 0, `rd_data` is 0 and every entry of both halves holds 0.
- R2: Each cycle with `line_start` high toggles `render_half`. The display side always reads the half that `render_half` does not name, and in cycles without `line_start` the selection holds.
- R3: With `wr_valid` high, lane i of `wr_data` (bits 24*i+23 down to 24*i) is stored at screen position `wr_x`+i of the render half. All lanes of one write are stored in the same cycle, for any value of `wr_x` modulo 8.
- R4: A lane whose `wr_mask` bit is 0 leaves its entry unchanged and adds nothing to the pixel count.
- R5: A lane whose position `wr_x`+i is 512 or more is discarded. It changes no entry and adds nothing to the pixel count.
- R6: `rd_en` high with `rd_x` returns the display-half entry at `rd_x` on `rd_data` one cycle later. In a cycle after one with `rd_en` low, `rd_data` is 0.
- R7: An entry that has been read holds 0 afterwards.
- R8: Stored pixels are counted per line, and `line_start` resets the count to 0. A write is accepted while the count plus its stored pixels stays at or below the budget. The budget is 3072 when `budget_mode` is 0 and 4096 when it is 1.
- R9: A write that would take the count past the budget stores none of its pixels. After such a write the line counts as exhausted, so every later write of that line that holds at least one storable pixel is dropped as well.
- R10: Writes into the render half do not appear in the display half until the halves are swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Render and readout clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Swaps the halves and restarts the pixel count |
| budget_mode | input | 1 | 0: budget of 3072 pixels, 1: budget of 4096 pixels |
| wr_valid | input | 1 | Render write request |
| wr_x | input | 10 | Screen position of lane 0 |
| wr_mask | input | 8 | Per-lane valid bits |
| wr_data | input | 192 | Eight 24-bit pixels, lane 0 in the low bits |
| rd_en | input | 1 | Readout request |
| rd_x | input | 9 | Readout position |
| rd_data | output | 24 | Entry read in the previous cycle, or 0 |
| render_half | output | 1 | Index of the half currently being drawn into |

## Verification
The hardest state to reach is the budget edge. The count has to sit a few pixels below the limit, and the next writes must then land exactly on the limit, cross it, or come after it has already been crossed. The bench gets there with hundreds of full eight-pixel writes stacked on the same positions. It then adds partial writes whose masked-out lanes and off-screen lanes would, if they were counted, push the total over at the wrong point. After the swap, it reads back which of the final fragments survived.

// File: rtl/sprite_line_buf.sv
module sprite_line_buf #(
  parameter int NPIX      = 512,
  parameter int PW        = 24,
  parameter int LANES     = 8,
  parameter int BUDGET_LO = 3072,
  parameter int BUDGET_HI = 4096
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  line_start,
  input  logic                  budget_mode,
  input  logic                  wr_valid,
  input  logic [$clog2(NPIX):0] wr_x,
  input  logic [LANES-1:0]      wr_mask,
  input  logic [LANES*PW-1:0]   wr_data,
  input  logic                  rd_en,
  input  logic [$clog2(NPIX)-1:0] rd_x,
  output logic [PW-1:0]         rd_data,
  output logic                  render_half
);
  localparam int XW   = $clog2(NPIX);
  localparam int SW   = $clog2(LANES);
  localparam int COLS = NPIX / LANES;
  localparam int CW   = $clog2(COLS);
  localparam int NW   = $clog2(LANES + 1);
  localparam int BW   = $clog2(BUDGET_HI + LANES + 1);

  logic [LANES-1:0] lane_ok;
  logic [NW-1:0]    n_pix;
  logic [BW-1:0]    draw_cnt, budget_now;
  logic [BW:0]      cnt_sum;
  logic             fits, wr_go;
  logic [SW-1:0]    off;
  logic [CW-1:0]    col0;
  logic [PW-1:0]    rdw [LANES];

  always_comb begin
    n_pix = '0;
    for (int i = 0; i < LANES; i++) begin
      lane_ok[i] = wr_mask[i] && (({1'b0, wr_x} + (XW+2)'(i)) < (XW+2)'(NPIX));
      n_pix = n_pix + NW'(lane_ok[i]);
    end
  end

  assign budget_now = budget_mode ? BW'(BUDGET_HI) : BW'(BUDGET_LO);
  assign cnt_sum    = {1'b0, draw_cnt} + (BW+1)'(n_pix);
  assign fits       = cnt_sum <= {1'b0, budget_now};
  assign wr_go      = wr_valid && fits;
  assign off        = wr_x[SW-1:0];
  assign col0       = wr_x[XW-1:SW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      render_half <= 1'b0;
      draw_cnt    <= '0;
    end else begin
      if (line_start) render_half <= ~render_half;
      if (line_start)
        draw_cnt <= '0;
      else if (wr_valid && n_pix != '0)
        draw_cnt <= fits ? cnt_sum[BW-1:0] : budget_now;
    end
  end

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    localparam logic [SW-1:0] BI = SW'(b);
    logic [PW-1:0]   mem [2*COLS];
    logic [SW-1:0]   li;
    logic [CW-1:0]   wcol;
    logic            we, rhit;
    logic [CW:0]     wa, ra;

    assign li   = BI - off;
    assign wcol = (BI >= off) ? col0 : col0 + CW'(1);
    assign we   = wr_go && lane_ok[li];
    assign wa   = {render_half, wcol};
    assign ra   = {~render_half, rd_x[XW-1:SW]};
    assign rhit = rd_en && (rd_x[SW-1:0] == BI);
    assign rdw[b] = mem[ra];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int k = 0; k < 2*COLS; k++) mem[k] <= '0;
      end else begin
        if (we)   mem[wa] <= wr_data[int'(li)*PW +: PW];
        if (rhit) mem[ra] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_en ? rdw[rd_x[SW-1:0]] : '0;
  end
endmodule

module sprite_line_buf_chk #(
  parameter int PW        = 24,
  parameter int BW        = 13,
  parameter int BUDGET_HI = 4096
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_start,
  input logic          rd_en,
  input logic          render_half,
  input logic [PW-1:0] rd_data,
  input logic [BW-1:0] draw_cnt,
  input logic [BW-1:0] budget_now
);
  assert_swap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> render_half != $past(render_half));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(render_half));
  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rd_data == '0);
  assert_count_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    draw_cnt <= BW'(BUDGET_HI));
  assert_count_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> draw_cnt == '0);
  assert_exhausted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start && draw_cnt == budget_now) |=> $stable(draw_cnt));
endmodule

bind sprite_line_buf sprite_line_buf_chk #(.PW(PW), .BW(BW), .BUDGET_HI(BUDGET_HI)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .rd_en(rd_en),
  .render_half(render_half), .rd_data(rd_data), .draw_cnt(draw_cnt),
  .budget_now(budget_now));

// File: tb/sprite_line_buf_tb.sv
module sprite_line_buf_tb_top;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         line_start = 0, budget_mode = 0, wr_valid = 0, rd_en = 0;
  logic [9:0]   wr_x = 0;
  logic [7:0]   wr_mask = 0;
  logic [191:0] wr_data = 0;
  logic [8:0]   rd_x = 0;
  logic [23:0]  rd_data;
  logic         render_half;
  int           n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  sprite_line_buf dut_i (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .budget_mode(budget_mode),
    .wr_valid(wr_valid), .wr_x(wr_x), .wr_mask(wr_mask), .wr_data(wr_data),
    .rd_en(rd_en), .rd_x(rd_x), .rd_data(rd_data), .render_half(render_half));

  function automatic logic [23:0] pix(int tag, int x);
    return {8'(tag), 16'(x)};
  endfunction

  task automatic chk(bit ok, string req, logic [23:0] act, logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int x, logic [7:0] m, int tag);
    @(negedge clk);
    wr_valid = 1; wr_x = 10'(x); wr_mask = m;
    for (int i = 0; i < 8; i++) wr_data[i*24 +: 24] = pix(tag, x + i);
    @(negedge clk);
    wr_valid = 0; wr_mask = 0;
  endtask

  task automatic swap();
    @(negedge clk); line_start = 1;
    @(negedge clk); line_start = 0;
  endtask

  task automatic rd_chk(int x, logic [23:0] exp, string req);
    @(negedge clk); rd_en = 1; rd_x = 9'(x);
    @(negedge clk); rd_en = 0;
    chk(rd_data === exp, req, rd_data, exp);
  endtask

  task automatic t_reset();
    chk(render_half === 1'b0, "R1 half", 24'(render_half), 0);
    chk(rd_data === '0, "R1 rd_data", rd_data, 0);
    rd_chk(0, 0, "R1 entry");
    rd_chk(511, 0, "R1 entry");
    @(negedge clk);
    chk(rd_data === '0, "R6 idle", rd_data, 0);
  endtask

  task automatic t_aligned();
    wr(64, 8'hFF, 1);
    rd_chk(64, 0, "R10 not visible before swap");
    swap();
    chk(render_half === 1'b1, "R2 toggle", 24'(render_half), 1);
    for (int x = 64; x < 72; x++) rd_chk(x, pix(1, x), "R3 aligned");
    rd_chk(64, 0, "R7 cleared");
  endtask

  task automatic t_unaligned();
    wr(131, 8'b1011_0111, 2);
    swap();
    chk(render_half === 1'b0, "R2 toggle back", 24'(render_half), 0);
    for (int x = 128; x < 141; x++) begin
      logic [23:0] e;
      int i = x - 131;
      e = (i >= 0 && i < 8 && ((8'b1011_0111 >> i) & 1) == 1) ? pix(2, x) : 24'h0;
      rd_chk(x, e, "R3 R4 unaligned");
    end
  endtask

  task automatic t_edge();
    wr(509, 8'hFF, 3);
    wr(600, 8'hFF, 4);
    swap();
    for (int x = 509; x < 512; x++) rd_chk(x, pix(3, x), "R5 tail lanes");
    rd_chk(88, 0, "R5 no wrap");
  endtask

  task automatic t_budget_lo();
    swap();
    budget_mode = 0;
    for (int k = 0; k < 383; k++) wr(0, 8'hFF, 5);
    wr(508, 8'hFF, 6);
    wr(200, 8'h0F, 7);
    wr(300, 8'h01, 8);
    swap();
    rd_chk(0, pix(5, 0), "R8 bulk");
    rd_chk(508, pix(6, 508), "R5 R8 edge write");
    rd_chk(200, pix(7, 200), "R4 R8 exact fit");
    rd_chk(203, pix(7, 203), "R4 R8 exact fit");
    rd_chk(204, 0, "R4 masked lane");
    rd_chk(300, 0, "R9 after limit");
  endtask

  task automatic t_budget_hi();
    budget_mode = 1;
    for (int k = 0; k < 510; k++) wr(0, 8'hFF, 9);
    wr(32, 8'hFF, 10);
    wr(64, 8'h3F, 11);
    wr(80, 8'h0F, 12);
    wr(96, 8'h01, 13);
    swap();
    rd_chk(32, pix(10, 32), "R8 count restarted");
    rd_chk(64, pix(11, 64), "R8 high budget");
    rd_chk(69, pix(11, 69), "R8 high budget");
    rd_chk(70, 0, "R4 masked lane");
    rd_chk(80, 0, "R9 whole write dropped");
    rd_chk(83, 0, "R9 whole write dropped");
    rd_chk(96, 0, "R9 exhausted line");
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000", cyc);
      finish_up();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_aligned();
    t_unaligned();
    t_edge();
    t_budget_lo();
    t_budget_hi();
    finish_up();
  end
endmodule